// File: doc/BRIEF.md
# Read/Write Bus Direction Scheduler

This block decides, cycle by cycle, whether the shared DRAM data bus is given to read bursts or to write bursts. It looks at how many requests wait in the read and write queues, whether each queue has a valid head entry, and a per-cycle burst pulse tagged as read or write. It answers with a direction grant and a pair of pulses that frame every change of direction.

Reads are preferred. A write drain starts when the write queue reaches a high watermark, or when there is nothing to read and something to write. Once started, a drain continues until a minimum number of writes has gone out and the write queue has fallen to a low watermark, or until the write queue is empty. Each change of direction passes through a turnaround state. In that state the bus stays idle for a configured number of cycles, and the read-to-write gap and the write-to-read gap are configured separately. The watermarks, the minimum writes per drain and both gaps are static configuration inputs.

Top module: `bus_dir_sched`

## Requirements
- R1: `dir_state` uses the encoding 0 = read phase, 1 = read-to-write turnaround, 2 = write phase, 3 = write-to-read turnaround. While reset is held, the state is 0, both phase counts are 0 and both pulses are low.
- R2: In the read phase the block leaves for the read-to-write turnaround when `wrq_count >= cfg_wr_hi`, or when `rdq_count == 0` and `wrq_count != 0`. In the cycle it makes that decision, no grant is given.
- R3: In the write phase the block leaves for the write-to-read turnaround when `wrq_count == 0`, or when the write phase count is at least `cfg_min_wr` and `wrq_count <= cfg_wr_lo`. In the cycle it makes that decision, no grant is given. Under continuous draining from an occupancy W with no new writes, the drain therefore issues min(W, max(`cfg_min_wr`, W − `cfg_wr_lo`)) writes, and the write phase lasts that many cycles plus one.
- R4: A read-to-write turnaround lasts max(`cfg_t_rtw`, 1) cycles and a write-to-read turnaround lasts max(`cfg_t_wtr`, 1) cycles. After each, the opposite phase follows.
- R5: `rd_phase_cnt` counts the reads accepted in the current read phase and `wr_phase_cnt` counts the writes accepted in the current write phase. Each count is 0 in the first cycle of its own phase and holds its value until that phase begins again.
- R6: `turn_start` is high exactly in the first cycle of each turnaround. `turn_end` is high exactly in the first cycle of the phase that follows a turnaround.
- R7: `grant_vld` is high only in the read phase with `rd_head_vld`, or in the write phase with `wr_head_vld`. `grant_wr` is 1 in the write phase and 0 otherwise. A burst is accepted only when `burst_fire`, `grant_vld` and `burst_is_wr == grant_wr` are all true, so a burst offered during a turnaround or in the wrong direction changes no count.
- R8: With both queues empty in the read phase, the block stays in the read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rdq_count | input | CW | Read-queue occupancy |
| wrq_count | input | CW | Write-queue occupancy |
| rd_head_vld | input | 1 | Read queue has a valid head entry |
| wr_head_vld | input | 1 | Write queue has a valid head entry |
| burst_fire | input | 1 | A burst is offered this cycle |
| burst_is_wr | input | 1 | Offered burst is a write (1) or a read (0) |
| cfg_wr_hi | input | CW | High write watermark |
| cfg_wr_lo | input | CW | Low write watermark |
| cfg_min_wr | input | CNTW | Minimum writes per drain |
| cfg_t_rtw | input | GAPW | Read-to-write gap in cycles |
| cfg_t_wtr | input | GAPW | Write-to-read gap in cycles |
| dir_state | output | 2 | Current direction state |
| grant_vld | output | 1 | Bus granted this cycle |
| grant_wr | output | 1 | Granted direction is write |
| turn_start | output | 1 | First cycle of a turnaround |
| turn_end | output | 1 | First cycle after a turnaround |
| rd_phase_cnt | output | CNTW | Reads accepted in the current or last read phase |
| wr_phase_cnt | output | CNTW | Writes accepted in the current or last write phase |

## Verification
The assertions rely on three assumptions. The configuration stays constant while reset is released, satisfies `cfg_wr_lo < cfg_wr_hi <= QDEPTH`, and keeps each head-valid flag consistent with a non-zero occupancy. The bench keeps to these assumptions. Each run reprograms the configuration only while reset is held, and a small queue model derives both head flags and both counts from the bursts actually accepted. Stray bursts offered during turnarounds change only the bench's own expectations of the counts, never its queue model.

// File: rtl/sched_pkg.sv
// Package: shared state type for the bus direction scheduler.
// Assumes nothing beyond a two-bit state field decoded by neighbours.
package sched_pkg;
    typedef enum logic [1:0] {
        DIR_RD    = 2'd0,
        DIR_RD2WR = 2'd1,
        DIR_WR    = 2'd2,
        DIR_WR2RD = 2'd3
    } dir_e;

    // True in either turnaround state.
    function automatic logic is_turn(dir_e d);
        return (d == DIR_RD2WR) || (d == DIR_WR2RD);
    endfunction
endpackage

// File: rtl/turn_gap_timer.sv
// Turnaround gap timer: loaded with a gap on the decision to switch,
// then counts down. 'done' is high once at most one cycle of gap is left,
// so a gap of 0 or 1 both give a single turnaround cycle.
// Assumes load is a single-cycle pulse issued one cycle before the gap.
module turn_gap_timer #(
    parameter int GAPW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [GAPW-1:0] load_val,
    output logic            done
);
    logic [GAPW-1:0] remain;

    // Load on switch decision, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    // Last gap cycle when one or none remains.
    always_comb done = (remain <= GAPW'(1));
endmodule

// File: rtl/phase_burst_counter.sv
// Saturating count of bursts accepted in one phase; cleared at phase entry.
// Assumes clear and incr are never both set (clear comes from a turnaround).
module phase_burst_counter #(
    parameter int CNTW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            incr,
    output logic [CNTW-1:0] count
);
    // Clear on phase entry, otherwise count accepted bursts up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (incr && (count != {CNTW{1'b1}}))
            count <= count + 1'b1;
    end
endmodule

// File: rtl/dir_fsm.sv
// Direction state machine: read phase, read-to-write gap, write phase,
// write-to-read gap. Decides when to switch from watermarks, the write
// phase count and queue emptiness; withholds the grant in a switch cycle.
// Assumes cfg_wr_lo < cfg_wr_hi and static configuration.
module dir_fsm
    import sched_pkg::*;
#(
    parameter int CW   = 5,
    parameter int CNTW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   rdq_count,
    input  logic [CW-1:0]   wrq_count,
    input  logic            rd_head_vld,
    input  logic            wr_head_vld,
    input  logic [CW-1:0]   cfg_wr_hi,
    input  logic [CW-1:0]   cfg_wr_lo,
    input  logic [CNTW-1:0] cfg_min_wr,
    input  logic [CNTW-1:0] wr_cnt,
    input  logic            gap_done,
    output dir_e            state,
    output logic            grant_vld,
    output logic            grant_wr,
    output logic            leave_now,
    output logic            enter_rd,
    output logic            enter_wr,
    output logic            turn_start,
    output logic            turn_end
);
    dir_e state_nx;
    logic rd_leave, wr_leave;

    // Switch conditions for each data phase.
    always_comb begin
        rd_leave = (wrq_count >= cfg_wr_hi) ||
                   ((rdq_count == '0) && (wrq_count != '0));
        wr_leave = (wrq_count == '0) ||
                   ((wr_cnt >= cfg_min_wr) && (wrq_count <= cfg_wr_lo));
    end

    // Next state, grant and phase-entry strobes.
    always_comb begin
        state_nx  = state;
        leave_now = 1'b0;
        enter_rd  = 1'b0;
        enter_wr  = 1'b0;
        grant_vld = 1'b0;
        grant_wr  = (state == DIR_WR);
        case (state)
            DIR_RD: begin
                leave_now = rd_leave;
                grant_vld = rd_head_vld && !rd_leave;
                if (rd_leave) state_nx = DIR_RD2WR;
            end
            DIR_RD2WR: begin
                enter_wr = gap_done;
                if (gap_done) state_nx = DIR_WR;
            end
            DIR_WR: begin
                leave_now = wr_leave;
                grant_vld = wr_head_vld && !wr_leave;
                if (wr_leave) state_nx = DIR_WR2RD;
            end
            default: begin
                enter_rd = gap_done;
                if (gap_done) state_nx = DIR_RD;
            end
        endcase
    end

    // State register and the registered turnaround pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= DIR_RD;
            turn_start <= 1'b0;
            turn_end   <= 1'b0;
        end else begin
            state      <= state_nx;
            turn_start <= leave_now;
            turn_end   <= enter_rd || enter_wr;
        end
    end

    // R1: only the four ring steps (stay or advance by one) are legal.
    assert_legal_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == $past(state)) || (state == dir_e'($past(state) + 2'd1)));

    // R2: a read-to-write switch needs the high mark or an empty read queue.
    assert_rd_leave_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DIR_RD2WR && $past(state) == DIR_RD) |->
        ($past(wrq_count) >= $past(cfg_wr_hi) || $past(rdq_count) == '0));

    // R3: a drain ends only after enough writes or with an empty write queue.
    assert_min_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DIR_WR2RD && $past(state) == DIR_WR) |->
        ($past(wr_cnt) >= $past(cfg_min_wr) || $past(wrq_count) == '0));
endmodule

// File: rtl/bus_dir_sched.sv
// Top of the read/write bus direction scheduler. Combines the direction
// machine, the shared turnaround gap timer and one phase counter per
// direction. Accepts a burst only when it matches the current grant.
// Assumes static configuration with cfg_wr_lo < cfg_wr_hi <= QDEPTH.
module bus_dir_sched
    import sched_pkg::*;
#(
    parameter  int QDEPTH = 16,
    parameter  int GAPW   = 4,
    parameter  int CNTW   = 6,
    localparam int CW     = $clog2(QDEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   rdq_count,
    input  logic [CW-1:0]   wrq_count,
    input  logic            rd_head_vld,
    input  logic            wr_head_vld,
    input  logic            burst_fire,
    input  logic            burst_is_wr,
    input  logic [CW-1:0]   cfg_wr_hi,
    input  logic [CW-1:0]   cfg_wr_lo,
    input  logic [CNTW-1:0] cfg_min_wr,
    input  logic [GAPW-1:0] cfg_t_rtw,
    input  logic [GAPW-1:0] cfg_t_wtr,
    output logic [1:0]      dir_state,
    output logic            grant_vld,
    output logic            grant_wr,
    output logic            turn_start,
    output logic            turn_end,
    output logic [CNTW-1:0] rd_phase_cnt,
    output logic [CNTW-1:0] wr_phase_cnt
);
    localparam int NDIR = 2;

    dir_e            state;
    logic            leave_now, enter_rd, enter_wr, gap_done, accept;
    logic [GAPW-1:0] gap_sel;
    logic            cnt_clear [NDIR];
    logic            cnt_incr  [NDIR];
    logic [CNTW-1:0] cnt_val   [NDIR];

    // Burst acceptance and the gap chosen for the coming turnaround.
    always_comb begin
        accept       = burst_fire && grant_vld && (burst_is_wr == grant_wr);
        gap_sel      = (state == DIR_RD) ? cfg_t_rtw : cfg_t_wtr;
        cnt_clear[0] = enter_rd;
        cnt_clear[1] = enter_wr;
        cnt_incr[0]  = accept && !burst_is_wr;
        cnt_incr[1]  = accept && burst_is_wr;
        dir_state    = state;
        rd_phase_cnt = cnt_val[0];
        wr_phase_cnt = cnt_val[1];
    end

    dir_fsm #(.CW(CW), .CNTW(CNTW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .rdq_count(rdq_count), .wrq_count(wrq_count),
        .rd_head_vld(rd_head_vld), .wr_head_vld(wr_head_vld),
        .cfg_wr_hi(cfg_wr_hi), .cfg_wr_lo(cfg_wr_lo), .cfg_min_wr(cfg_min_wr),
        .wr_cnt(cnt_val[1]), .gap_done(gap_done),
        .state(state), .grant_vld(grant_vld), .grant_wr(grant_wr),
        .leave_now(leave_now), .enter_rd(enter_rd), .enter_wr(enter_wr),
        .turn_start(turn_start), .turn_end(turn_end)
    );

    turn_gap_timer #(.GAPW(GAPW)) u_gap (
        .clk(clk), .rst_n(rst_n),
        .load(leave_now), .load_val(gap_sel), .done(gap_done)
    );

    for (genvar d = 0; d < NDIR; d++) begin : g_cnt
        phase_burst_counter #(.CNTW(CNTW)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .clear(cnt_clear[d]), .incr(cnt_incr[d]), .count(cnt_val[d])
        );
    end

    // Checker: length of the turnaround in progress, in cycles minus one.
    logic [GAPW:0] chk_len;
    always_ff @(posedge clk) begin
        if (!rst_n || !is_turn(state))
            chk_len <= '0;
        else
            chk_len <= chk_len + 1'b1;
    end

    // R4: each turnaround lasts max(gap,1) cycles.
    assert_rtw_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == DIR_RD2WR && state == DIR_WR) |->
        (int'($past(chk_len)) + 1 ==
         (($past(cfg_t_rtw) == '0) ? 1 : int'($past(cfg_t_rtw)))));
    assert_wtr_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == DIR_WR2RD && state == DIR_RD) |->
        (int'($past(chk_len)) + 1 ==
         (($past(cfg_t_wtr) == '0) ? 1 : int'($past(cfg_t_wtr)))));

    // R5: the read count reads zero in the first cycle of a read phase.
    assert_rd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (turn_end && state == DIR_RD) |-> (rd_phase_cnt == '0));

    // R6: the start pulse only appears inside a turnaround.
    assert_start_in_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        turn_start |-> is_turn(state));

    // R7: outside the read phase no read can move the read count.
    assert_rd_count_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != DIR_RD && $past(state) != DIR_RD) |-> $stable(rd_phase_cnt));
endmodule

// File: tb/sim_bus_dir_sched.sv
module sim_bus_dir_sched;
    localparam int QDEPTH = 16;
    localparam int GAPW   = 4;
    localparam int CNTW   = 6;
    localparam int CW     = $clog2(QDEPTH + 1);
    localparam int HI     = 8;
    localparam int LO     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] rdq_count = '0, wrq_count = '0;
    logic rd_head_vld = 1'b0, wr_head_vld = 1'b0;
    logic burst_fire = 1'b0, burst_is_wr = 1'b0;
    logic [CW-1:0] cfg_wr_hi = CW'(HI), cfg_wr_lo = CW'(LO);
    logic [CNTW-1:0] cfg_min_wr = '0;
    logic [GAPW-1:0] cfg_t_rtw = '0, cfg_t_wtr = '0;
    logic [1:0] dir_state;
    logic grant_vld, grant_wr, turn_start, turn_end;
    logic [CNTW-1:0] rd_phase_cnt, wr_phase_cnt;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    bus_dir_sched #(.QDEPTH(QDEPTH), .GAPW(GAPW), .CNTW(CNTW)) u0 (
        .clk(clk), .rst_n(rst_n), .rdq_count(rdq_count), .wrq_count(wrq_count),
        .rd_head_vld(rd_head_vld), .wr_head_vld(wr_head_vld),
        .burst_fire(burst_fire), .burst_is_wr(burst_is_wr),
        .cfg_wr_hi(cfg_wr_hi), .cfg_wr_lo(cfg_wr_lo), .cfg_min_wr(cfg_min_wr),
        .cfg_t_rtw(cfg_t_rtw), .cfg_t_wtr(cfg_t_wtr),
        .dir_state(dir_state), .grant_vld(grant_vld), .grant_wr(grant_wr),
        .turn_start(turn_start), .turn_end(turn_end),
        .rd_phase_cnt(rd_phase_cnt), .wr_phase_cnt(wr_phase_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int gapcyc(input int g);
        return (g == 0) ? 1 : g;
    endfunction

    // One scenario: 2 reads, write burst of HI arrives, drain, return, reads.
    task automatic run_case(input int g_rtw, input int g_wtr, input int mw);
        int rdq, wrq, seg, prev, ts_cnt, te_cnt, wexp, wdone;
        int len [6];
        bit fire, fire_wr, acc;
        rdq = 6; wrq = 0; seg = 0; prev = 0; ts_cnt = 0; te_cnt = 0; wdone = 0;
        fire = 0; fire_wr = 0; acc = 0;
        for (int k = 0; k < 6; k++) len[k] = 0;
        wexp = (mw > HI - LO) ? mw : HI - LO;
        if (wexp > HI) wexp = HI;
        @(negedge clk);
        rst_n = 1'b0; burst_fire = 1'b0;
        cfg_t_rtw = GAPW'(g_rtw); cfg_t_wtr = GAPW'(g_wtr); cfg_min_wr = CNTW'(mw);
        rdq_count = CW'(rdq); wrq_count = CW'(wrq);
        rd_head_vld = 1'b1; wr_head_vld = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset state
        check(dir_state == 2'd0 && rd_phase_cnt == 0 && wr_phase_cnt == 0 &&
              !turn_start && !turn_end, "R1 reset", int'(dir_state), 0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 80; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (acc) begin
                if (fire_wr) wrq--; else rdq--;
            end
            if (cyc == 2) wrq = HI;
            rdq_count = CW'(rdq); wrq_count = CW'(wrq);
            rd_head_vld = (rdq > 0); wr_head_vld = (wrq > 0);
            #1;
            if (cyc > 0 && int'(dir_state) != prev) begin
                seg++;
                case (seg)
                    1: begin
                        check(dir_state == 2'd1, "R2 high mark switch", int'(dir_state), 1);
                        check(len[0] == 3, "R2 read phase length", len[0], 3);
                        check(turn_start, "R6 start at r2w", int'(turn_start), 1);
                        check(rd_phase_cnt == 2, "R5 reads before switch", int'(rd_phase_cnt), 2);
                    end
                    2: begin
                        check(len[1] == gapcyc(g_rtw), "R4 rtw length", len[1], gapcyc(g_rtw));
                        check(turn_end, "R6 end into write", int'(turn_end), 1);
                        check(wr_phase_cnt == 0, "R5 write count cleared", int'(wr_phase_cnt), 0);
                        check(grant_wr, "R7 write grant dir", int'(grant_wr), 1);
                    end
                    3: begin
                        check(wdone == wexp, "R3 writes per drain", wdone, wexp);
                        check(len[2] == wexp + 1, "R3 write phase length", len[2], wexp + 1);
                        check(int'(wr_phase_cnt) == wexp, "R5 write count", int'(wr_phase_cnt), wexp);
                        check(turn_start, "R6 start at w2r", int'(turn_start), 1);
                    end
                    4: begin
                        check(len[3] == gapcyc(g_wtr), "R4 wtr length", len[3], gapcyc(g_wtr));
                        check(turn_end, "R6 end into read", int'(turn_end), 1);
                        check(rd_phase_cnt == 0, "R5 read count cleared", int'(rd_phase_cnt), 0);
                    end
                    default: begin
                        check(dir_state == 2'd1 && rdq == 0 && wrq < HI,
                              "R2 empty read queue switch", wrq, HI - wexp);
                        check(rd_phase_cnt == 4, "R5 reads in second phase", int'(rd_phase_cnt), 4);
                        check(len[4] == 5, "R2 second read phase length", len[4], 5);
                    end
                endcase
            end
            prev = int'(dir_state);
            len[seg]++;
            ts_cnt += int'(turn_start);
            te_cnt += int'(turn_end);
            if (seg == 1)
                check(rd_phase_cnt == 2, "R7 reads ignored in r2w", int'(rd_phase_cnt), 2);
            if (seg == 3)
                check(int'(wr_phase_cnt) == wexp, "R7 writes ignored in w2r", int'(wr_phase_cnt), wexp);
            if (seg == 1 || seg == 3)
                check(!grant_vld, "R7 no grant in turnaround", int'(grant_vld), 0);
            if (seg == 5) break;
            if (dir_state == 2'd1) begin fire = 1; fire_wr = 0; end
            else if (dir_state == 2'd3) begin fire = 1; fire_wr = 1; end
            else begin fire = grant_vld; fire_wr = grant_wr; end
            burst_fire = fire; burst_is_wr = fire_wr;
            acc = fire && grant_vld && (fire_wr == grant_wr);
            if (acc && fire_wr && seg == 2) wdone++;
        end
        if (wexp == HI) begin
            check(seg == 4 && dir_state == 2'd0, "R8 idle stays in read", int'(dir_state), 0);
            check(rd_phase_cnt == 4, "R5 reads held when idle", int'(rd_phase_cnt), 4);
            check(ts_cnt == 2 && te_cnt == 2, "R6 pulse count idle", ts_cnt, 2);
        end else begin
            check(seg == 5, "R2 reached second switch", seg, 5);
            check(ts_cnt == 3 && te_cnt == 2, "R6 pulse count", ts_cnt, 3);
        end
        burst_fire = 1'b0;
    endtask

    initial begin
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                run_case(a, b, 3);
        for (int m = 0; m < 10; m++)
            run_case(2, 1, m);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule